// File: doc/BRIEF.md
# Service-Request Poll Address Scheduler

This block decides which device on a shared peripheral bus the host should poll next after a transaction ends. Each device has a 4-bit address. The host asks a device for data by sending a command byte whose upper nibble is the address and whose lower nibble is the talk-register-zero code. The block receives the set of devices enabled for polling, the last command byte the host sent, and a flag. The flag reports that some device raised a service request during the last transaction.

The block keeps the command byte of the most recent talk-register-zero poll, and uses its address as the base. It stays on that base unless one of two things holds. The first is that a service request arrived while that same poll was the last command sent, so the polled device cannot have been the one asking. The second is that the base has left the enabled set. When either holds, it moves to the next enabled address above the base, wrapping to the lowest enabled address if there is none above.

It reports no poll when the enabled set is empty. It also reports none when the chosen command matches the last command sent, because the bus transceiver already repeats that command while the bus is idle. The result is registered and appears one clock after a start strobe.

Top module: `srq_poll_sched`

## Requirements
- R1: One clock after `start` is high at a rising edge, `res_rdy` is high for exactly one cycle. `poll_req` is never high unless `res_rdy` is high.
- R2: Bit 0 of `dev_mask` has no effect, so a requested poll always carries an address from 1 to 15.
- R3: When `dev_mask` bits 15..1 are all zero, `poll_req` stays low.
- R4: `poll_cmd` carries the chosen address in bits [7:4] and the talk-register-zero code 0xC in bits [3:0].
- R5: The base address is bits [7:4] of the stored last-poll command. With no service request, and the base still enabled, the chosen address equals the base.
- R6: When `srq_seen` is high and `last_cmd` equals the stored last-poll command, the address moves on even if the base is still enabled.
- R7: When the base address is not enabled, the address moves on whatever `srq_seen` is.
- R8: Moving on selects the lowest enabled address strictly above the base. If there is none, it wraps to the lowest enabled address overall.
- R9: When the chosen command equals `last_cmd`, `poll_req` stays low.
- R10: The stored last-poll command loads `last_cmd` only in a cycle where `cmd_done` is high and `last_cmd[3:0]` is 0xC. A completed command with any other low nibble leaves it unchanged.
- R11: After reset the stored last-poll command is 0x00, which gives base address 0. `res_rdy`, `poll_req` and `poll_cmd` are zero.
- R12: With `srq_seen` high but `last_cmd` different from the stored last-poll command, an enabled base is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Strobe that samples the inputs and starts one decision |
| dev_mask | input | 16 | Enabled-device set, bit n for address n |
| last_cmd | input | 8 | Last command byte sent on the bus |
| srq_seen | input | 1 | A service request was seen in the last transaction |
| cmd_done | input | 1 | `last_cmd` has just finished its command phase |
| res_rdy | output | 1 | Decision result valid, one cycle |
| poll_req | output | 1 | A new poll must be queued |
| poll_cmd | output | 8 | Poll command byte to queue |

## Verification
Every decision is due exactly one clock after the `start` strobe. The bench raises `start` on a falling edge and drops it on the next falling edge. It then reads `res_rdy`, `poll_req` and `poll_cmd` at that second falling edge, half a period after the single register stage has loaded. A load of the last-poll register through `cmd_done` takes effect at the rising edge in between. The next decision is started only after that load, and this decision brings out the stored base through the normal outputs. The sweep covers every base address against walking-bit, empty, full and scrambled masks, both `srq_seen` values and three `last_cmd` relations.

// File: rtl/srq_poll_pkg.sv
package srq_poll_pkg;
   // default geometry of the command byte
   localparam int unsigned SRQ_ADDR_W_DEF = 4;
   localparam int unsigned SRQ_OP_W_DEF   = 4;
   // code in the low field that selects talk, register zero
   localparam logic [3:0]  SRQ_TALK0_DEF  = 4'hC;

   typedef enum logic [0:0] {
      SEL_KEEP = 1'b0,
      SEL_MOVE = 1'b1
   } sel_mode_e;
endpackage

// File: rtl/srq_lowest_pick.sv
module srq_lowest_pick #(
   parameter int unsigned N     = 16,
   parameter int unsigned IDX_W = 4
) (
   input  logic [N-1:0]     vec,
   output logic [IDX_W-1:0] idx
);
   logic [N-1:0] seen_below;
   logic [N-1:0] first_hot;

   assign seen_below[0] = 1'b0;
   genvar gi;
   generate
      for (gi = 1; gi < N; gi++) begin : g_chain
         assign seen_below[gi] = seen_below[gi-1] | vec[gi-1];
      end
      for (gi = 0; gi < N; gi++) begin : g_first
         assign first_hot[gi] = vec[gi] & ~seen_below[gi];
      end
   endgenerate

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (first_hot[i]) idx = idx | IDX_W'(i);
      end
   end
endmodule

// File: rtl/srq_last_poll_reg.sv
module srq_last_poll_reg #(
   parameter int unsigned CMD_W = 8,
   parameter int unsigned OP_W  = 4,
   parameter logic [OP_W-1:0] TALK0_CODE = 4'hC
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_done,
   input  logic [CMD_W-1:0] last_cmd,
   output logic [CMD_W-1:0] lp_cmd
);
   logic is_talk0;
   assign is_talk0 = (last_cmd[OP_W-1:0] == TALK0_CODE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    lp_cmd <= '0;
      else if (cmd_done && is_talk0) lp_cmd <= last_cmd;
   end

   // stored poll only changes on a completed talk-zero command
   assert_lp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_done && is_talk0) |=> $stable(lp_cmd));
   assert_lp_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_done && is_talk0) |=> (lp_cmd == $past(last_cmd)));
endmodule

// File: rtl/srq_addr_select.sv
module srq_addr_select
   import srq_poll_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned OP_W   = 4,
   parameter logic [OP_W-1:0] TALK0_CODE = 4'hC,
   localparam int unsigned CMD_W    = ADDR_W + OP_W,
   localparam int unsigned NUM_ADDR = 1 << ADDR_W
) (
   input  logic [NUM_ADDR-1:0] dev_mask,
   input  logic [CMD_W-1:0]    last_cmd,
   input  logic [CMD_W-1:0]    lp_cmd,
   input  logic                srq_seen,
   output logic [CMD_W-1:0]    next_cmd,
   output logic                need_poll
);
   logic [NUM_ADDR-1:0] elig;
   logic [NUM_ADDR-1:0] above;
   logic [NUM_ADDR-1:0] pick_vec;
   logic [ADDR_W-1:0]   base;
   logic [ADDR_W-1:0]   pick_idx;
   logic [ADDR_W-1:0]   addr;
   sel_mode_e           mode;

   // address zero never takes part
   assign elig = dev_mask & ~NUM_ADDR'(1);
   assign base = lp_cmd[CMD_W-1:OP_W];

   always_comb begin
      for (int i = 0; i < NUM_ADDR; i++) begin
         above[i] = elig[i] & (ADDR_W'(i) > base);
      end
   end

   assign pick_vec = (|above) ? above : elig;

   srq_lowest_pick #(.N(NUM_ADDR), .IDX_W(ADDR_W)) u_pick (
      .vec (pick_vec),
      .idx (pick_idx)
   );

   always_comb begin
      if ((srq_seen && (last_cmd == lp_cmd)) || !elig[base]) mode = SEL_MOVE;
      else                                                   mode = SEL_KEEP;
   end

   assign addr      = (mode == SEL_MOVE) ? pick_idx : base;
   assign next_cmd  = {addr, TALK0_CODE};
   assign need_poll = (|elig) && (next_cmd != last_cmd);
endmodule

// File: rtl/srq_poll_sched.sv
module srq_poll_sched
   import srq_poll_pkg::*;
#(
   parameter int unsigned ADDR_W = SRQ_ADDR_W_DEF,
   parameter int unsigned OP_W   = SRQ_OP_W_DEF,
   parameter logic [OP_W-1:0] TALK0_CODE = SRQ_TALK0_DEF,
   localparam int unsigned CMD_W    = ADDR_W + OP_W,
   localparam int unsigned NUM_ADDR = 1 << ADDR_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [NUM_ADDR-1:0] dev_mask,
   input  logic [CMD_W-1:0]    last_cmd,
   input  logic                srq_seen,
   input  logic                cmd_done,
   output logic                res_rdy,
   output logic                poll_req,
   output logic [CMD_W-1:0]    poll_cmd
);
   generate
      if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_addr_w
         $error("srq_poll_sched: ADDR_W out of range");
      end
      if (OP_W < 1) begin : g_bad_op_w
         $error("srq_poll_sched: OP_W must be positive");
      end
   endgenerate

   logic [CMD_W-1:0]  lp_cmd;
   logic [CMD_W-1:0]  next_cmd;
   logic              need_poll;
   logic [ADDR_W-1:0] lp_addr;

   assign lp_addr = lp_cmd[CMD_W-1:OP_W];

   srq_last_poll_reg #(.CMD_W(CMD_W), .OP_W(OP_W), .TALK0_CODE(TALK0_CODE)) u_lp (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_done (cmd_done),
      .last_cmd (last_cmd),
      .lp_cmd   (lp_cmd)
   );

   srq_addr_select #(.ADDR_W(ADDR_W), .OP_W(OP_W), .TALK0_CODE(TALK0_CODE)) u_sel (
      .dev_mask  (dev_mask),
      .last_cmd  (last_cmd),
      .lp_cmd    (lp_cmd),
      .srq_seen  (srq_seen),
      .next_cmd  (next_cmd),
      .need_poll (need_poll)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_rdy  <= 1'b0;
         poll_req <= 1'b0;
         poll_cmd <= '0;
      end else begin
         res_rdy  <= start;
         poll_req <= start & need_poll;
         if (start) poll_cmd <= next_cmd;
      end
   end

   assert_rdy_after_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> res_rdy);
   assert_rdy_only_after_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
      res_rdy |-> $past(start));
   assert_req_with_rdy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      poll_req |-> res_rdy);
   assert_no_addr_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      poll_req |-> (poll_cmd[CMD_W-1:OP_W] != '0));
   assert_empty_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (dev_mask[NUM_ADDR-1:1] == '0)) |=> !poll_req);
   assert_talk0_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
      poll_req |-> (poll_cmd[OP_W-1:0] == TALK0_CODE));
   assert_keep_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !srq_seen && (lp_addr != '0) && dev_mask[lp_addr])
      |=> (poll_cmd[CMD_W-1:OP_W] == $past(lp_addr)));
   assert_no_repeat_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !(poll_req && (poll_cmd == $past(last_cmd))));
endmodule

// File: tb/srq_poll_sched_bench.sv
module srq_poll_sched_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 200000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] dev_mask = '0;
   logic [7:0]  last_cmd = '0;
   logic        srq_seen = 1'b0;
   logic        cmd_done = 1'b0;
   logic        res_rdy;
   logic        poll_req;
   logic [7:0]  poll_cmd;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   srq_poll_sched u_srq_poll_sched (
      .clk(clk), .rst_n(rst_n), .start(start), .dev_mask(dev_mask),
      .last_cmd(last_cmd), .srq_seen(srq_seen), .cmd_done(cmd_done),
      .res_rdy(res_rdy), .poll_req(poll_req), .poll_cmd(poll_cmd)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // expected decision from the requirements
   function automatic void model(input logic [7:0] lpc, input logic [15:0] m,
                                 input bit s, input logic [7:0] lc,
                                 output int ea, output bit en);
      logic [15:0] em;
      int base;
      bit mv;
      em   = m & 16'hFFFE;
      base = int'(lpc[7:4]);
      mv   = (s && (lc == lpc)) || !em[base];
      ea   = -1;
      if (!mv) ea = base;
      else begin
         for (int a = base + 1; a < 16; a++) if (em[a] && ea < 0) ea = a;
         for (int a = 1; a < 16; a++) if (em[a] && ea < 0) ea = a;
      end
      if (ea < 0) ea = 0;
      en = (em != 0) && ({ea[3:0], 4'hC} != lc);
   endfunction

   task automatic load_lp(input logic [7:0] c);
      @(negedge clk);
      last_cmd = c; cmd_done = 1'b1;
      @(negedge clk);
      cmd_done = 1'b0;
   endtask

   task automatic decide(input logic [15:0] m, input bit s, input logic [7:0] lc);
      @(negedge clk);
      dev_mask = m; srq_seen = s; last_cmd = lc; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic run_case(input string tag, input logic [7:0] lpc, input logic [15:0] m,
                           input bit s, input logic [7:0] lc);
      int ea; bit en;
      model(lpc, m, s, lc, ea, en);
      decide(m, s, lc);
      check({tag, " R1 rdy"}, 16'(res_rdy), 16'd1);
      check({tag, " R3/R9 req"}, 16'(poll_req), 16'(en));
      if ((m & 16'hFFFE) != 0)
         check({tag, " R4/R8 cmd"}, 16'(poll_cmd), 16'({ea[3:0], 4'hC}));
   endtask

   initial begin
      while (!finished) begin
         @(posedge clk);
         cycles++;
         if (cycles >= WATCHDOG && !finished) begin
            finished = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11 rdy", 16'(res_rdy), 16'd0);
      check("R11 req", 16'(poll_req), 16'd0);
      check("R11 cmd", 16'(poll_cmd), 16'd0);
      rst_n = 1'b1;
      // R11 base address 0 after reset: not enabled, moves to lowest
      decide(16'h0006, 1'b0, 8'h00);
      check("R11 base0", 16'(poll_cmd), 16'h001C);
      check("R11 base0 req", 16'(poll_req), 16'd1);
      @(negedge clk);
      check("R1 single pulse", 16'(res_rdy), 16'd0);

      // R2 bit 0 alone counts as empty (R3)
      load_lp(8'h3C);
      run_case("R2", 8'h3C, 16'h0001, 1'b0, 8'h00);
      // R10 non-talk-zero completion ignored
      load_lp(8'h53);
      load_lp(8'h7D);
      decide(16'hFFFE, 1'b0, 8'h00);
      check("R10 ignore", 16'(poll_cmd), 16'h003C);
      // R12 srq with unrelated last command keeps base
      run_case("R12", 8'h3C, 16'h0108, 1'b1, 8'h91);
      check("R12 keep", 16'(poll_cmd), 16'h003C);
      // R6 srq with last == last poll moves
      run_case("R6", 8'h3C, 16'h0108, 1'b1, 8'h3C);
      check("R6 move", 16'(poll_cmd), 16'h008C);
      // R9 suppression with base kept
      run_case("R9", 8'h3C, 16'h0108, 1'b0, 8'h3C);
      check("R9 suppress", 16'(poll_req), 16'd0);
      // R7 base dropped; R8 wrap
      load_lp(8'hEC);
      run_case("R7/R8 wrap", 8'hEC, 16'h0024, 1'b0, 8'h00);
      check("R8 wrap addr", 16'(poll_cmd), 16'h002C);

      // sweep: every base, many masks, srq both ways, three last-command relations
      for (int b = 0; b < 16; b++) begin
         for (int i = 0; i < 40; i++) begin
            logic [15:0] m;
            if (i < 16)       m = 16'(1 << i);
            else if (i == 16) m = 16'h0000;
            else if (i == 17) m = 16'hFFFF;
            else              m = 16'((i * 40503) ^ (i * i * 97) ^ (b << 9));
            for (int s = 0; s < 2; s++) begin
               for (int k = 0; k < 3; k++) begin
                  logic [7:0] lpc;
                  logic [7:0] lc;
                  lpc = {4'(b), 4'hC};
                  case (k)
                     0:       lc = lpc;
                     1:       lc = {4'(b + 1), 4'hC};
                     default: lc = 8'h37 ^ 8'(b);
                  endcase
                  load_lp(lpc);
                  run_case("R5/R6/R7/R8 sweep", lpc, m, bit'(s), lc);
               end
            end
         end
      end

      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule